// File: doc/BRIEF.md
# Interval-Based Manchester Frame Decoder

This block recovers the bits of a Manchester-coded response frame from a single demodulated line. It looks only at the falling transitions of that line. A free-running counter measures the distance between consecutive falling edges in carrier periods, where one carrier period is one pulse of the `tick` strobe. Each measured interval is sorted into a class. Depending on the class, on the last decoded bit and on the start-of-frame state, the interval yields no bit, one bit or two bits.

An interval long enough to follow a silent line opens a new frame and records the response latency. The first few decoded bits of every frame form a header, and they are discarded. The remaining bits are packed MSB-first into a byte buffer, and a running count is kept beside it. When the line stays quiet long enough, the block closes the frame with a one-cycle `frame_done` pulse.

The frame leaves the block as a single-cycle valid with no ready. During the `frame_done` cycle, `frame_data`, `bit_count` and `latency` hold the finished frame. On the following cycle the buffer and the count are cleared. A consumer therefore cannot apply back-pressure: it must capture the frame in the pulse cycle. Interval timing is carried by `tick` and `demod_in`, which are plain inputs.

Top module: `mc_frame_decoder`

## Requirements
- R1: While reset is held, and directly after it, `frame_done` is 0 and `bit_count`, `frame_data` and `latency` are all zero.
- R2: A falling edge whose interval is 80 ticks or more opens a frame and sets `latency` to the interval minus 16. The interval counter saturates at 255, so the first frame after reset reports 239.
- R3: Inside a frame, an interval of 57 to 79 ticks decodes a 0 followed by a 1, and the last bit becomes 1.
- R4: An interval of 41 to 56 ticks decodes a 0 followed by a 1, and the last bit becomes 1. The exception is the first such interval of a frame that arrives while header bits are still being dropped: it decodes only the 0, and the last bit becomes 0.
- R5: An interval of 25 to 40 ticks decodes one copy of the last bit. The last bit is 1 when a frame opens.
- R6: An interval shorter than 25 ticks decodes nothing. The next interval is still measured from that edge.
- R7: The first 4 decoded bits of each frame are dropped and are not counted.
- R8: Kept bit number n is stored in byte n/8, at bit 7-(n mod 8) of that byte. Byte k occupies `frame_data[8k+7:8k]`.
- R9: The buffer holds at most 160 bits. Later bits are lost, and `bit_count` stays at 160.
- R10: When a frame is open and more than 80 ticks pass with no falling edge, `frame_done` pulses for exactly one cycle, once per frame, while the outputs still hold that frame.
- R11: On the cycle after `frame_done`, `bit_count` and `frame_data` are zero.
- R12: Only falling transitions of `demod_in` count as edges. Where the rising transition falls inside an interval has no effect on the decoded frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One pulse per carrier period |
| demod_in | input | 1 | Demodulated line from the front end |
| frame_done | output | 1 | One-cycle pulse; the frame outputs are valid in this cycle |
| bit_count | output | 8 | Number of kept bits in the buffer |
| latency | output | 8 | Start interval minus 16, in ticks |
| frame_data | output | 160 | Packed frame bytes, byte k at bits 8k+7..8k |

## Verification
The hardest state to reach is the single header-phase mid interval that yields only a 0. It has to coincide with header dropping that straddles a two-bit interval, so that one bit of a pair is dropped and the other is kept. Directed frames place a mid interval immediately after the start, and then a long interval where exactly one header bit remains.

The other hard state is buffer saturation. It needs a frame of more than 164 decodable intervals, which a directed run of repeat intervals supplies. Seeded random frames then mix noise, boundary intervals and random rising-edge positions, and a bench model of the interval rules predicts each frame.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  // interval classes, ordered from shortest to longest
  typedef enum logic [2:0] {
    IV_NOISE,
    IV_SAME,
    IV_MID,
    IV_LONG,
    IV_START
  } ivcls_e;
endpackage

// File: rtl/mcd_fall_detect.sv
module mcd_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line;
  end

  assign fall = prev_q & ~line;
endmodule

// File: rtl/mcd_interval.sv
module mcd_interval #(
  parameter int IVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           fall,
  output logic [IVW-1:0] ival
);
  localparam logic [IVW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  ival <= TOP;
    else if (fall)               ival <= {{(IVW-1){1'b0}}, tick};
    else if (tick && ival != TOP) ival <= ival + 1'b1;
  end

  // a new interval starts from zero (or one when a tick coincides)
  assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (ival <= {{(IVW-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/mcd_decode.sv
module mcd_decode
  import mcd_pkg::*;
#(
  parameter int IVW      = 8,
  parameter int HALF     = 16,
  parameter int T_SAME   = 25,
  parameter int T_MID    = 41,
  parameter int T_LONG   = 57,
  parameter int T_START  = 80,
  parameter int HDR_BITS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fall,
  input  logic           in_frame,
  input  logic [IVW-1:0] ival,
  output logic           start,
  output logic [1:0]     n_keep,
  output logic           kb0,
  output logic           kb1,
  output logic [IVW-1:0] latency
);
  localparam int HW = $clog2(HDR_BITS + 2);

  ivcls_e        cls;
  logic [HW-1:0] hdr_q, hdr_mid, hdr_d;
  logic          skip_q, last_q, skip_d, last_d;
  logic [1:0]    n_raw;
  logic          r0, r1, drop0, drop1;

  always_comb begin
    if      (ival >= IVW'(T_START)) cls = IV_START;
    else if (ival >= IVW'(T_LONG))  cls = IV_LONG;
    else if (ival >= IVW'(T_MID))   cls = IV_MID;
    else if (ival >= IVW'(T_SAME))  cls = IV_SAME;
    else                            cls = IV_NOISE;
  end

  assign start = fall && (cls == IV_START);

  // raw bits produced by this edge
  always_comb begin
    n_raw  = 2'd0;
    r0     = 1'b0;
    r1     = 1'b0;
    last_d = last_q;
    skip_d = skip_q;
    if (fall && in_frame) begin
      case (cls)
        IV_LONG: begin
          n_raw  = 2'd2;
          r1     = 1'b1;
          last_d = 1'b1;
        end
        IV_MID: begin
          if (skip_q && hdr_q != '0) begin
            n_raw  = 2'd1;
            skip_d = 1'b0;
            last_d = 1'b0;
          end else begin
            n_raw  = 2'd2;
            r1     = 1'b1;
            last_d = 1'b1;
          end
        end
        IV_SAME: begin
          n_raw = 2'd1;
          r0    = last_q;
        end
        default: ;
      endcase
    end
  end

  // header filter, applied bit by bit in decode order
  always_comb begin
    drop0   = (n_raw != 2'd0) && (hdr_q != '0);
    hdr_mid = hdr_q - HW'(drop0);
    drop1   = (n_raw == 2'd2) && (hdr_mid != '0);
    hdr_d   = hdr_mid - HW'(drop1);
    if (drop0) begin
      kb0    = r1;
      kb1    = 1'b0;
      n_keep = (n_raw == 2'd2 && !drop1) ? 2'd1 : 2'd0;
    end else begin
      kb0    = r0;
      kb1    = r1;
      n_keep = n_raw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q   <= '0;
      skip_q  <= 1'b0;
      last_q  <= 1'b1;
      latency <= '0;
    end else if (start) begin
      hdr_q   <= HW'(HDR_BITS);
      skip_q  <= 1'b1;
      last_q  <= 1'b1;
      latency <= ival - IVW'(HALF);
    end else begin
      hdr_q  <= hdr_d;
      skip_q <= skip_d;
      last_q <= last_d;
    end
  end

  // once any bit is kept the header phase is over
  assert_header_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (n_keep != 2'd0) |=> (hdr_q == '0));
endmodule

// File: rtl/mcd_buffer.sv
module mcd_buffer #(
  parameter int CAP = 160,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [1:0]     n_keep,
  input  logic           kb0,
  input  logic           kb1,
  output logic [CW-1:0]  bit_count,
  output logic [CAP-1:0] data
);
  localparam int IW = $clog2(CAP);

  function automatic logic [IW-1:0] slot(input int n);
    return IW'(8 * (n / 8) + 7 - (n % 8));
  endfunction

  logic [CAP-1:0] data_d;
  logic [CW:0]    sum;

  always_comb begin
    data_d = data;
    if (n_keep != 2'd0 && int'(bit_count) < CAP)
      data_d[slot(int'(bit_count))] = kb0;
    if (n_keep == 2'd2 && int'(bit_count) + 1 < CAP)
      data_d[slot(int'(bit_count) + 1)] = kb1;
    sum = {1'b0, bit_count} + {{(CW-1){1'b0}}, n_keep};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      data      <= '0;
      bit_count <= '0;
    end else begin
      data      <= data_d;
      bit_count <= (sum > (CW+1)'(CAP)) ? CW'(CAP) : sum[CW-1:0];
    end
  end

  assert_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bit_count == '0));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_count) <= CAP);
  assert_count_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (bit_count >= $past(bit_count)));
endmodule

// File: rtl/mc_frame_decoder.sv
module mc_frame_decoder #(
  parameter int IVW       = 8,
  parameter int HALF      = 16,
  parameter int T_SAME    = 25,
  parameter int T_MID     = 41,
  parameter int T_LONG    = 57,
  parameter int T_START   = 80,
  parameter int HDR_BITS  = 4,
  parameter int MAX_BYTES = 20
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             demod_in,
  output logic                             frame_done,
  output logic [$clog2(8*MAX_BYTES+1)-1:0] bit_count,
  output logic [IVW-1:0]                   latency,
  output logic [8*MAX_BYTES-1:0]           frame_data
);
  localparam int CAP = 8 * MAX_BYTES;
  localparam int CW  = $clog2(CAP + 1);

  logic           fall, start, kb0, kb1, in_frame, silence, clr;
  logic [IVW-1:0] ival;
  logic [1:0]     n_keep;

  mcd_fall_detect u_fall (
    .clk(clk), .rst_n(rst_n), .line(demod_in), .fall(fall)
  );

  mcd_interval #(.IVW(IVW)) u_ival (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fall(fall), .ival(ival)
  );

  mcd_decode #(
    .IVW(IVW), .HALF(HALF), .T_SAME(T_SAME), .T_MID(T_MID),
    .T_LONG(T_LONG), .T_START(T_START), .HDR_BITS(HDR_BITS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .fall(fall), .in_frame(in_frame), .ival(ival),
    .start(start), .n_keep(n_keep), .kb0(kb0), .kb1(kb1), .latency(latency)
  );

  mcd_buffer #(.CAP(CAP), .CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .n_keep(n_keep), .kb0(kb0), .kb1(kb1),
    .bit_count(bit_count), .data(frame_data)
  );

  assign silence = in_frame && !fall && (ival > IVW'(T_START));
  assign clr     = frame_done | start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= silence;
      if (start)        in_frame <= 1'b1;
      else if (silence) in_frame <= 1'b0;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !in_frame);
endmodule

// File: tb/sim_mc_frame_decoder.sv
module sim_mc_frame_decoder;
  localparam int CAP = 160;
  localparam int HDR = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b1;
  logic           demod_in = 1'b0;
  logic           frame_done;
  logic [7:0]     bit_count;
  logic [7:0]     latency;
  logic [CAP-1:0] frame_data;

  always #10 clk = ~clk;

  mc_frame_decoder u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .demod_in(demod_in),
    .frame_done(frame_done), .bit_count(bit_count), .latency(latency),
    .frame_data(frame_data)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int ivals[0:255];
  int nivals;
  logic [CAP-1:0] exp_data;
  int exp_cnt, exp_lat;
  string exp_tag;
  logic [CAP-1:0] snap_data;
  int snap_cnt, snap_lat;
  int done_seen = 0, done_expect = 0;
  bit clr_pend = 1'b0, prev_done = 1'b0, have_prev = 1'b0, first_frame = 1'b1;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", "run did not end act hung exp done");
    finish_run();
  end

  // frame capture, one-cycle pulse (R10) and clear (R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) begin
        snap_data = frame_data;
        snap_cnt  = int'(bit_count);
        snap_lat  = int'(latency);
        done_seen++;
        check(!prev_done, "R10", "frame_done longer than one cycle act 2 exp 1");
        clr_pend = 1'b1;
      end else if (clr_pend) begin
        clr_pend = 1'b0;
        check(bit_count == 0 && frame_data == '0, "R11",
              $sformatf("after done act cnt %0d data %h exp 0", bit_count, frame_data));
      end
      prev_done = frame_done;
    end
  end

  function automatic int slot(input int n);
    return 8 * (n / 8) + 7 - (n % 8);
  endfunction

  // reference model of the interval rules
  task automatic model();
    int hdr, cnt;
    bit skip, last;
    hdr = HDR; skip = 1'b1; last = 1'b1; cnt = 0;
    exp_data = '0;
    exp_lat = ivals[0] - 16;
    for (int i = 1; i < nivals; i++) begin
      int v;
      int nb;
      bit b[2];
      v = ivals[i];
      nb = 0;
      if (v >= 57) begin b[0] = 0; b[1] = 1; nb = 2; last = 1; end
      else if (v >= 41) begin
        if (skip && hdr > 0) begin b[0] = 0; nb = 1; skip = 0; last = 0; end
        else begin b[0] = 0; b[1] = 1; nb = 2; last = 1; end
      end
      else if (v >= 25) begin b[0] = last; nb = 1; end
      for (int j = 0; j < nb; j++) begin
        if (hdr > 0) hdr--;
        else begin
          if (cnt < CAP) exp_data[slot(cnt)] = b[j];
          if (cnt < CAP) cnt++;
        end
      end
    end
    exp_cnt = cnt;
  endtask

  // next falling edge k cycles after the previous one; rise after r cycles
  task automatic gap(input int k, input int r);
    @(posedge clk);
    @(negedge clk);
    repeat (r) @(negedge clk);
    demod_in = 1'b1;
    repeat (k - 1 - r) @(negedge clk);
    demod_in = 1'b0;
  endtask

  task automatic verify_prev();
    check(done_seen == done_expect, "R10",
          $sformatf("%s done pulses act %0d exp %0d", exp_tag, done_seen, done_expect));
    check(snap_cnt == exp_cnt, exp_tag,
          $sformatf("bit_count act %0d exp %0d", snap_cnt, exp_cnt));
    check(snap_data == exp_data, exp_tag,
          $sformatf("R8 data act %h exp %h", snap_data, exp_data));
    check(snap_lat == exp_lat, "R2",
          $sformatf("%s latency act %0d exp %0d", exp_tag, snap_lat, exp_lat));
  endtask

  task automatic send_frame(input string tag, input bit rand_rise);
    int k0;
    k0 = ivals[0];
    gap(k0, 3);
    if (have_prev) verify_prev();
    ivals[0] = first_frame ? 255 : (k0 > 255 ? 255 : k0);
    first_frame = 1'b0;
    model();
    exp_tag = tag;
    for (int i = 1; i < nivals; i++) begin
      int rr;
      rr = rand_rise ? int'($urandom % 32'(ivals[i] - 1)) : 3;
      gap(ivals[i], rr);
    end
    have_prev = 1'b1;
    done_expect++;
  endtask

  function automatic int pick_ival();
    int p;
    p = int'($urandom % 10);
    if (p == 0)      return 5 + int'($urandom % 20);
    else if (p < 4)  return 25 + int'($urandom % 16);
    else if (p < 7)  return 41 + int'($urandom % 16);
    else             return 57 + int'($urandom % 23);
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(frame_done == 0, "R1", $sformatf("frame_done act %0d exp 0", frame_done));
    check(bit_count == 0, "R1", $sformatf("bit_count act %0d exp 0", bit_count));
    check(frame_data == '0, "R1", $sformatf("frame_data act %h exp 0", frame_data));
    check(latency == 0, "R1", $sformatf("latency act %0d exp 0", latency));
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_done == 0 && bit_count == 0, "R1", "after release act nonzero exp 0");

    // R4 header skip, R5 repeat, R7 drop, R2 saturated latency 239
    ivals[0] = 100;
    ivals[1] = 44; ivals[2] = 28; ivals[3] = 28; ivals[4] = 60;
    ivals[5] = 30; ivals[6] = 60; ivals[7] = 44; ivals[8] = 28;
    nivals = 9;
    send_frame("R4_R5_R7", 1'b0);

    // R6 noise edges ignored, timing restarts from them
    ivals[0] = 120;
    ivals[1] = 44; ivals[2] = 10; ivals[3] = 30; ivals[4] = 20; ivals[5] = 60;
    ivals[6] = 15; ivals[7] = 15; ivals[8] = 44; ivals[9] = 30; ivals[10] = 24;
    ivals[11] = 57;
    nivals = 12;
    send_frame("R6", 1'b0);

    // R3 class boundaries
    ivals[0] = 90;
    ivals[1] = 79; ivals[2] = 57; ivals[3] = 25; ivals[4] = 56; ivals[5] = 41;
    ivals[6] = 40; ivals[7] = 24; ivals[8] = 57; ivals[9] = 41; ivals[10] = 25;
    nivals = 11;
    send_frame("R3", 1'b0);

    // R7 frame fully consumed by header
    ivals[0] = 200;
    ivals[1] = 44; ivals[2] = 30;
    nivals = 3;
    send_frame("R7", 1'b0);

    // R9 overflow past 160 bits
    ivals[0] = 150;
    for (int i = 1; i < 171; i++) ivals[i] = 30;
    ivals[1] = 60;
    nivals = 171;
    send_frame("R9", 1'b0);

    // R12 random frames with random rising-edge positions
    for (int f = 0; f < 20; f++) begin
      ivals[0] = 90 + int'($urandom % 160);
      nivals = 2 + int'($urandom % 40);
      for (int i = 1; i < nivals; i++) ivals[i] = pick_ival();
      send_frame("R12", 1'b1);
    end

    repeat (120) @(negedge clk);
    verify_prev();
    finish_run();
  end
endmodule